// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a page mapping by reading an in-memory translation tree. A walk starts from a context table whose base comes from a pointer register and whose row is picked by the current context number. Each word read is classified by its two-bit type field. A pointer word sends the walk one level down. A leaf word ends the walk. An invalid or unusable word ends it with a fault.

A translation unit sends a virtual address on a valid/ready request channel. The walker issues one word read at a time on a simple memory port and returns the final word, the level where it stopped, the decoded leaf attributes and a fault flag. A leaf found at level 1 covers 16 MB, at level 2 it covers 256 KB and at level 3 it covers a 4 KB page. A leaf found in the context table itself covers the whole space. On a fault, two held registers take the faulting virtual address and a status code.

Top module: `tblwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `rsp_valid`=0, `mem_req`=0, `flt_status`=0 and `flt_addr`=0.
- R2: The first read of a walk is at `((ctx_table_ptr & 0xFFFFFFF0) << 4) + 4*ctx_num`. The low four bits of the pointer register have no effect, and every context number up to the widest value is reached.
- R3: After a pointer word W (type 1) read at level L<3, the next read is at `(W & 0xFFFFFFF0) + 4*idx`, where idx is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: A leaf word (type 2) ends the walk with `rsp_fault`=0, `rsp_entry` equal to that word and `rsp_level` equal to the level where it was read (0 for the context table, 1 to 3 below it).
- R5: For a leaf, `rsp_cacheable` is entry bit 7, `rsp_modified` is bit 6, `rsp_referenced` is bit 5 and `rsp_perm` is bits [4:2].
- R6: An invalid word (type 0) at any level ends the walk with `rsp_fault`=1 and `flt_status` = {level[1:0], 2'b01}.
- R7: A reverse-endian leaf word (type 3) ends the walk with `rsp_fault`=1 and `flt_status` = {level, 2'b10}.
- R8: A pointer word read at level 3 ends the walk with `rsp_fault`=1, `rsp_level`=3 and `flt_status`=4'b1111.
- R9: On a fault, `flt_addr` takes the walk's virtual address. Walks that end without a fault leave `flt_addr` and `flt_status` unchanged.
- R10: `mem_req` and `mem_addr` stay steady until `mem_rvalid` arrives, whatever the read latency, and only one read is outstanding at a time.
- R11: `req_ready` is 0 from the cycle after acceptance until the response handshake. While `rsp_ready` is 0, `rsp_valid` and the response fields hold.
- R12: `mem_rvalid` pulses that arrive while `mem_req` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_table_ptr | input | 32 | Context table base, physical address shifted right by 4 |
| ctx_num | input | CTX_W (16) | Current context number |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Walk result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_entry | output | 32 | Final word read (leaf or faulting word) |
| rsp_level | output | 2 | Level where the walk stopped |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cacheable | output | 1 | Leaf cacheable bit |
| rsp_modified | output | 1 | Leaf modified bit |
| rsp_referenced | output | 1 | Leaf referenced bit |
| rsp_perm | output | 3 | Leaf access-permission code |
| mem_req | output | 1 | Word read request, held until data |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| flt_status | output | 4 | Last fault: {level, type} |
| flt_addr | output | 32 | Last faulting virtual address |

## Verification
Walks are run that end at each depth: a leaf in the context table, at level 1, at level 2 and at level 3. Comparing the logged read addresses tells apart the index field used at each level and the masking of pointer words. Faulting walks place an invalid word, a reverse-endian word and a too-deep pointer at different levels, so the status code shows both the level and the cause. Further runs stretch the memory latency, hold back the response, inject read-data pulses while the walker is idle, use the highest context number, and set junk in the low pointer bits. These runs separate correct handshaking and ignoring from behaviour that only looks right under zero-latency timing.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;

    localparam int WORD_W   = 32;
    localparam int LVL_W    = 2;
    localparam int MAX_LVL  = 3;
    localparam int L1_LSB   = 24;
    localparam int L1_W     = 8;
    localparam int L2_LSB   = 18;
    localparam int L2_W     = 6;
    localparam int L3_LSB   = 12;
    localparam int L3_W     = 6;
    localparam int VPN_W    = WORD_W - L3_LSB;
    localparam int DESC_LSB = 4;
    localparam int STAT_W   = LVL_W + 2;

    typedef enum logic [1:0] {
        ET_INVALID   = 2'd0,
        ET_DESC      = 2'd1,
        ET_LEAF      = 2'd2,
        ET_LEAF_SWAP = 2'd3
    } etype_t;

    typedef enum logic [1:0] {
        FT_NONE     = 2'd0,
        FT_INVALID  = 2'd1,
        FT_RESERVED = 2'd2,
        FT_DEPTH    = 2'd3
    } ftype_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_RESP = 2'd2
    } wstate_t;

    typedef struct packed {
        logic   is_desc;
        logic   is_leaf;
        ftype_t ftype;
    } verdict_t;

    typedef struct packed {
        logic       cache;
        logic       modified;
        logic       referenced;
        logic [2:0] perm;
    } leafattr_t;

    function automatic logic [WORD_W-1:0] desc_base(input logic [WORD_W-1:0] w);
        return {w[WORD_W-1:DESC_LSB], {DESC_LSB{1'b0}}};
    endfunction

    function automatic leafattr_t leaf_attr(input logic [WORD_W-1:0] w);
        leafattr_t a;
        a.cache      = w[7];
        a.modified   = w[6];
        a.referenced = w[5];
        a.perm       = w[4:2];
        return a;
    endfunction

endpackage

// File: rtl/tblwalk_classify.sv
module tblwalk_classify
    import tblwalk_pkg::*;
(
    input  etype_t                etype,
    input  logic [LVL_W-1:0]      level,
    output verdict_t              verdict
);
    always_comb begin
        verdict = '{is_desc: 1'b0, is_leaf: 1'b0, ftype: FT_NONE};
        unique case (etype)
            ET_INVALID:   verdict.ftype = FT_INVALID;
            ET_DESC: begin
                if (level == LVL_W'(MAX_LVL)) verdict.ftype = FT_DEPTH;
                else                          verdict.is_desc = 1'b1;
            end
            ET_LEAF:      verdict.is_leaf = 1'b1;
            ET_LEAF_SWAP: verdict.ftype = FT_RESERVED;
        endcase
    end
endmodule

// File: rtl/tblwalk_addrgen.sv
module tblwalk_addrgen
    import tblwalk_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  logic [LVL_W-1:0]  level,
    input  logic [WORD_W-1:0] root_ptr,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [WORD_W-1:0] tbl_base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [WORD_W-1:0] addr
);
    localparam int SH = DESC_LSB;

    logic [WORD_W-1:0] root_base;
    logic [WORD_W-1:0] off_ctx, off_l1, off_l2, off_l3;
    logic              unused_root_bits;

    assign unused_root_bits = ^{root_ptr[WORD_W-1:WORD_W-SH], root_ptr[SH-1:0]};
    assign root_base = {root_ptr[WORD_W-SH-1:SH], {(2*SH){1'b0}}};

    assign off_ctx = WORD_W'({ctx, 2'b00});
    assign off_l1  = WORD_W'({vpn[L1_LSB-L3_LSB +: L1_W], 2'b00});
    assign off_l2  = WORD_W'({vpn[L2_LSB-L3_LSB +: L2_W], 2'b00});
    assign off_l3  = WORD_W'({vpn[0 +: L3_W], 2'b00});

    always_comb begin
        unique case (level)
            2'd0:    addr = root_base + off_ctx;
            2'd1:    addr = tbl_base + off_l1;
            2'd2:    addr = tbl_base + off_l2;
            default: addr = tbl_base + off_l3;
        endcase
    end
endmodule

// File: rtl/tblwalk_faultlog.sv
module tblwalk_faultlog
    import tblwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] vaddr,
    input  logic [STAT_W-1:0] status,
    output logic [WORD_W-1:0] flt_addr,
    output logic [STAT_W-1:0] flt_status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_addr   <= '0;
            flt_status <= '0;
        end else if (load) begin
            flt_addr   <= vaddr;
            flt_status <= status;
        end
    end
endmodule

// File: rtl/tblwalk_top.sv
module tblwalk_top
    import tblwalk_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ctx_table_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_entry,
    output logic [1:0]        rsp_level,
    output logic              rsp_fault,
    output logic              rsp_cacheable,
    output logic              rsp_modified,
    output logic              rsp_referenced,
    output logic [2:0]        rsp_perm,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [3:0]        flt_status,
    output logic [31:0]       flt_addr
);
    wstate_t           state_q;
    logic [LVL_W-1:0]  level_q;
    logic [WORD_W-1:0] va_q;
    logic [WORD_W-1:0] root_q;
    logic [CTX_W-1:0]  ctx_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] entry_q;
    logic              fault_q;

    verdict_t          verdict;
    leafattr_t         attr;
    logic              rd_done;
    logic              flt_load;
    logic [STAT_W-1:0] flt_code;

    assign rd_done = (state_q == ST_READ) && mem_rvalid;

    tblwalk_classify u_classify (
        .etype   (etype_t'(mem_rdata[1:0])),
        .level   (level_q),
        .verdict (verdict)
    );

    tblwalk_addrgen #(.CTX_W(CTX_W)) u_addrgen (
        .level    (level_q),
        .root_ptr (root_q),
        .ctx      (ctx_q),
        .tbl_base (base_q),
        .vpn      (va_q[WORD_W-1:L3_LSB]),
        .addr     (mem_addr)
    );

    assign flt_load = rd_done && !verdict.is_desc && !verdict.is_leaf;
    assign flt_code = {level_q, verdict.ftype};

    tblwalk_faultlog u_faultlog (
        .clk        (clk),
        .rst        (rst),
        .load       (flt_load),
        .vaddr      (va_q),
        .status     (flt_code),
        .flt_addr   (flt_addr),
        .flt_status (flt_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            va_q    <= '0;
            root_q  <= '0;
            ctx_q   <= '0;
            base_q  <= '0;
            entry_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        root_q  <= ctx_table_ptr;
                        ctx_q   <= ctx_num;
                        level_q <= '0;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_rvalid) begin
                        if (verdict.is_desc) begin
                            base_q  <= desc_base(mem_rdata);
                            level_q <= level_q + 1'b1;
                        end else begin
                            entry_q <= mem_rdata;
                            fault_q <= !verdict.is_leaf;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign attr           = leaf_attr(entry_q);
    assign req_ready      = (state_q == ST_IDLE);
    assign mem_req        = (state_q == ST_READ);
    assign rsp_valid      = (state_q == ST_RESP);
    assign rsp_entry      = entry_q;
    assign rsp_level      = level_q;
    assign rsp_fault      = fault_q;
    assign rsp_cacheable  = attr.cache;
    assign rsp_modified   = attr.modified;
    assign rsp_referenced = attr.referenced;
    assign rsp_perm       = attr.perm;
endmodule

// File: rtl/tblwalk_chk.sv
module tblwalk_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_entry,
    input logic [1:0]  rsp_level,
    input logic        rsp_fault,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic [3:0]  flt_status,
    input logic [31:0] flt_addr
);
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_entry)
                                    && $stable(rsp_level) && $stable(rsp_fault));

    assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && (rsp_valid || mem_req)));

    assert_leaf_type_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_entry[1:0] == 2'b10);

    assert_fault_code_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> flt_status[1:0] != 2'b00 && flt_status[3:2] == rsp_level);

    assert_fault_log_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_addr) || !$stable(flt_status) |-> $rose(rsp_valid) && rsp_fault);
endmodule

bind tblwalk_top tblwalk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_entry  (rsp_entry),
    .rsp_level  (rsp_level),
    .rsp_fault  (rsp_fault),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .flt_status (flt_status),
    .flt_addr   (flt_addr)
);

// File: tb/tb_tblwalk_top.sv
module tb_tblwalk_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctx_table_ptr = '0;
    logic [15:0] ctx_num = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_entry;
    logic [1:0]  rsp_level;
    logic        rsp_fault;
    logic        rsp_cacheable, rsp_modified, rsp_referenced;
    logic [2:0]  rsp_perm;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic [3:0]  flt_status;
    logic [31:0] flt_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int lat = 0;
    bit stray_en = 1'b0;
    bit hold_bad = 1'b0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] addr_log [$];
    logic got_c, got_m, got_r;
    logic [2:0] got_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    tblwalk_top dut (
        .clk(clk), .rst(rst), .ctx_table_ptr(ctx_table_ptr), .ctx_num(ctx_num),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_entry(rsp_entry),
        .rsp_level(rsp_level), .rsp_fault(rsp_fault), .rsp_cacheable(rsp_cacheable),
        .rsp_modified(rsp_modified), .rsp_referenced(rsp_referenced), .rsp_perm(rsp_perm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .flt_status(flt_status), .flt_addr(flt_addr)
    );

    // Memory responder: serves one read after lat waiting cycles, logs addresses.
    initial begin
        int waited;
        logic [31:0] held;
        waited = 0;
        held = '0;
        mem_rvalid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (waited > 0 && mem_addr != held) hold_bad = 1'b1;
                held = mem_addr;
                if (waited >= lat) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    addr_log.push_back(mem_addr);
                    waited = 0;
                end else begin
                    waited++;
                end
            end else if (stray_en) begin
                mem_rvalid = 1'b1;
                mem_rdata = 32'hFFFF_FF02;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic do_walk(input string tag, input logic [31:0] va, input logic [31:0] ptr,
                           input logic [15:0] ctx, input bit exp_fault,
                           input logic [31:0] exp_entry, input logic [1:0] exp_lvl,
                           input logic [31:0] ea [4], input int na, input int hold_cycles,
                           input logic [31:0] exp_faddr, input logic [3:0] exp_fstat);
        int n;
        addr_log.delete();
        @(negedge clk);
        ctx_table_ptr = ptr;
        ctx_num = ctx;
        req_vaddr = va;
        req_valid = 1'b1;
        rsp_ready = (hold_cycles == 0);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_valid, {tag, " R4 response arrives"}, 32'(rsp_valid), 32'd1);
        if (hold_cycles > 0) begin
            repeat (hold_cycles) @(negedge clk);
            chk(rsp_valid && !req_ready, {tag, " R11 response held"}, {30'd0, rsp_valid, req_ready}, 32'd2);
        end
        chk(rsp_entry == exp_entry, {tag, " R4 entry"}, rsp_entry, exp_entry);
        chk(rsp_level == exp_lvl, {tag, " R4 level"}, 32'(rsp_level), 32'(exp_lvl));
        chk(rsp_fault == exp_fault, {tag, " R6 fault flag"}, 32'(rsp_fault), 32'(exp_fault));
        chk(flt_addr == exp_faddr, {tag, " R9 fault address"}, flt_addr, exp_faddr);
        chk(flt_status == exp_fstat, {tag, " R9 fault status"}, 32'(flt_status), 32'(exp_fstat));
        chk(addr_log.size() == na, {tag, " R3 read count"}, 32'(addr_log.size()), 32'(na));
        for (int i = 0; i < na && i < addr_log.size(); i++)
            chk(addr_log[i] == ea[i], {tag, " R3 read address"}, addr_log[i], ea[i]);
        got_c = rsp_cacheable;
        got_m = rsp_modified;
        got_r = rsp_referenced;
        got_p = rsp_perm;
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid, {tag, " R11 idle after handshake"}, {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic chk_attr(input string tag, input logic c, input logic m, input logic r, input logic [2:0] p);
        chk({got_c, got_m, got_r, got_p} == {c, m, r, p}, {tag, " R5 leaf attributes"},
            32'({got_c, got_m, got_r, got_p}), 32'({c, m, r, p}));
    endtask

    localparam logic [31:0] PTR = 32'h0001_000F; // base 0x0010_0000, junk low bits

    task automatic t_reset();
        chk(req_ready && !rsp_valid && !mem_req, "R1 idle outputs",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
        chk(flt_status == 4'h0 && flt_addr == 32'h0, "R1 fault registers", flt_addr, 32'h0);
    endtask

    task automatic t_leaf_l3();
        do_walk("L3 leaf", 32'h1234_5678, PTR, 16'd5, 1'b0, 32'hABCD_E0AE, 2'd3,
                '{32'h0010_0014, 32'h0020_0048, 32'h0030_0034, 32'h0040_0014}, 4, 0, 32'h0, 4'h0);
        chk_attr("L3 leaf", 1'b1, 1'b0, 1'b1, 3'd3);
    endtask

    task automatic t_leaf_l1();
        do_walk("L1 leaf", 32'h7F00_0000, PTR, 16'd5, 1'b0, 32'h1100_0062, 2'd1,
                '{32'h0010_0014, 32'h0020_01FC, 32'h0, 32'h0}, 2, 0, 32'h0, 4'h0);
        chk_attr("L1 leaf", 1'b0, 1'b1, 1'b1, 3'd0);
    endtask

    task automatic t_leaf_l2_held();
        do_walk("L2 leaf held", 32'h12C0_0000, PTR, 16'd5, 1'b0, 32'h2222_22DE, 2'd2,
                '{32'h0010_0014, 32'h0020_0048, 32'h0030_00C0, 32'h0}, 3, 4, 32'h0, 4'h0);
        chk_attr("L2 leaf", 1'b1, 1'b1, 1'b0, 3'd7);
    endtask

    task automatic t_faults();
        do_walk("R6 invalid at L1", 32'h3300_0000, PTR, 16'd5, 1'b1, 32'h0, 2'd1,
                '{32'h0010_0014, 32'h0020_00CC, 32'h0, 32'h0}, 2, 0, 32'h3300_0000, 4'h5);
        do_walk("R7 reserved at L2", 32'h1244_0000, PTR, 16'd5, 1'b1, 32'h5555_5503, 2'd2,
                '{32'h0010_0014, 32'h0020_0048, 32'h0030_0044, 32'h0}, 3, 0, 32'h1244_0000, 4'hA);
        do_walk("R8 pointer at L3", 32'h1234_7000, PTR, 16'd5, 1'b1, 32'h0050_0001, 2'd3,
                '{32'h0010_0014, 32'h0020_0048, 32'h0030_0034, 32'h0040_001C}, 4, 0, 32'h1234_7000, 4'hF);
    endtask

    task automatic t_root_leaf();
        // Successful walk after a fault: fault registers keep the last fault (R9).
        do_walk("R2 root leaf", 32'hDEAD_B000, 32'h0001_0000, 16'd9, 1'b0, 32'h9999_0086, 2'd0,
                '{32'h0010_0024, 32'h0, 32'h0, 32'h0}, 1, 0, 32'h1234_7000, 4'hF);
        chk_attr("root leaf", 1'b1, 1'b0, 1'b0, 3'd1);
        do_walk("R2 top context", 32'h0000_1000, PTR, 16'hFFFF, 1'b0, 32'h0000_0002, 2'd0,
                '{32'h0013_FFFC, 32'h0, 32'h0, 32'h0}, 1, 0, 32'h1234_7000, 4'hF);
        do_walk("R6 invalid at root", 32'hCAFE_0000, PTR, 16'd10, 1'b1, 32'h0, 2'd0,
                '{32'h0010_0028, 32'h0, 32'h0, 32'h0}, 1, 0, 32'hCAFE_0000, 4'h1);
    endtask

    task automatic t_latency();
        lat = 3;
        do_walk("R10 slow memory", 32'h1234_5678, PTR, 16'd5, 1'b0, 32'hABCD_E0AE, 2'd3,
                '{32'h0010_0014, 32'h0020_0048, 32'h0030_0034, 32'h0040_0014}, 4, 0, 32'hCAFE_0000, 4'h1);
        chk(!hold_bad, "R10 address steady while waiting", 32'(hold_bad), 32'd0);
        lat = 0;
    endtask

    task automatic t_stray();
        @(negedge clk);
        stray_en = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(req_ready && !rsp_valid && !mem_req, "R12 stray read data ignored",
                {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
        end
        stray_en = 1'b0;
        chk(flt_status == 4'h1 && flt_addr == 32'hCAFE_0000, "R12 fault registers untouched",
            flt_addr, 32'hCAFE_0000);
        do_walk("R12 walk after stray", 32'h7F00_0000, PTR, 16'd5, 1'b0, 32'h1100_0062, 2'd1,
                '{32'h0010_0014, 32'h0020_01FC, 32'h0, 32'h0}, 2, 0, 32'hCAFE_0000, 4'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        mem[32'h0010_0014] = 32'h0020_0001; // ctx 5 -> L1 table
        mem[32'h0010_0024] = 32'h9999_0086; // ctx 9 leaf
        mem[32'h0013_FFFC] = 32'h0000_0002; // ctx 0xFFFF leaf
        mem[32'h0020_0048] = 32'h0030_0001; // L1[0x12] -> L2 table
        mem[32'h0020_01FC] = 32'h1100_0062; // L1[0x7F] leaf
        mem[32'h0030_0034] = 32'h0040_0001; // L2[0x0D] -> L3 table
        mem[32'h0030_00C0] = 32'h2222_22DE; // L2[0x30] leaf
        mem[32'h0030_0044] = 32'h5555_5503; // L2[0x11] reversed leaf
        mem[32'h0040_0014] = 32'hABCD_E0AE; // L3[5] leaf
        mem[32'h0040_001C] = 32'h0050_0001; // L3[7] pointer
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_leaf_l3();
        t_leaf_l1();
        t_leaf_l2_held();
        t_faults();
        t_root_leaf();
        t_latency();
        t_stray();
        summary();
    end
endmodule